// File: doc/BRIEF.md
# Two-Segment Instruction Expander

This block rebuilds one 32-bit instruction from a compressed bit string. The string arrives left-aligned in an input window, with its first bit in the window's most significant bit. The upper 16-bit half of the instruction is not carried in the string. Only a short index is carried, and the block uses it to read a vocabulary table. That table lives in one of two external vocabulary RAMs, and a select bit in the string picks the RAM for each instruction. The lower 16-bit half is carried as a bypass field. Its width is picked by a 4-bit length code held in configuration.

The surrounding fetch logic presents a window with `in_valid` and the configuration fields that apply to the class. When the block takes the window, it issues one read to the chosen vocabulary RAM. One cycle later it offers the full instruction on a valid/ready output, together with the number of compressed bits it consumed, so that the fetch logic can advance its bit pointer. An instruction that cannot be decoded raises a one-cycle error pulse instead of producing output.

Both vocabulary RAMs are synchronous. A RAM returns data on the cycle after its enable, and it keeps that data while its enable stays low. Configuration must stay stable while `in_valid` is high. The window must be at least 30 bits wide.

Top module: `insn_seg_expander`

## Requirements
- R1: Field order in the window, from the most significant bit down: the 4-bit class at [31:28], the select bit at [27], then an index of L bits, then a bypass field of B bits. Any bits below these fields are ignored.
- R2: A class field that differs from the parameter CLASS_ID (default 4'h6) is a decode error.
- R3: The index length L comes from `cfg_idx_len` and is valid from 2 to 9. Any other value is a decode error.
- R4: `cfg_tail_code` values 4'hB, 4'hC, 4'hD and 4'hE select a bypass width B of 0, 10, 15 and 16 bits. Every other code is a decode error.
- R5: When the select bit is 0, the block reads RAM A at `cfg_base_a` plus the index, modulo 512, and leaves RAM B idle. When the select bit is 1, it reads RAM B at `cfg_base_b` plus the index in the same way. Exactly one enable is high, and only in the cycle in which a valid window is taken.
- R6: The lower instruction half is the bypass field, zero-extended. A width of 0 gives 16'h0000.
- R7: `out_len` equals 5 + L + B.
- R8: A valid window taken at a clock edge makes `out_valid` high from that edge on. `out_instr` then reads {vocabulary word, lower half}.
- R9: While `out_valid` is high and `out_ready` is low, `out_instr` and `out_len` hold their values and `in_ready` is low.
- R10: A decode error gives a one-cycle `out_err` pulse after the edge that took the window. It raises no `out_valid` and enables neither RAM.
- R11: After reset, `out_valid` and `out_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | The window holds an instruction |
| in_ready | output | 1 | The block can take a window |
| in_window | input | WIN_W | Compressed bits, left-aligned |
| cfg_idx_len | input | 4 | Index length L |
| cfg_tail_code | input | 4 | Bypass length code |
| cfg_base_a | input | VOC_AW | Table base in RAM A |
| cfg_base_b | input | VOC_AW | Table base in RAM B |
| voc_a_en | output | 1 | RAM A read enable |
| voc_a_addr | output | VOC_AW | RAM A read address |
| voc_a_data | input | SEG_W | RAM A read data, one cycle after enable |
| voc_b_en | output | 1 | RAM B read enable |
| voc_b_addr | output | VOC_AW | RAM B read address |
| voc_b_data | input | SEG_W | RAM B read data, one cycle after enable |
| out_valid | output | 1 | An instruction is offered |
| out_ready | input | 1 | The consumer takes the instruction |
| out_instr | output | 2*SEG_W | Rebuilt instruction |
| out_len | output | LEN_W | Compressed bits consumed |
| out_err | output | 1 | Decode error pulse |

## Verification
The bench sweeps every valid index length against every bypass code for both RAM selects, using all-ones, all-zeros and mixed field patterns. It also places junk bits below the fields. A design with a wrong shift, or one that does not mask the bypass field, would shift those junk bits into the lower half or the index and give a wrong word or address. RAM A's base sits close to 512, so a design that carried beyond nine address bits would read the wrong entry. Every invalid code, every invalid index length and a wrong class are each shown to pulse the error flag without a RAM read or an output. Stalls of several cycles check that the instruction stays the same after the RAM output is no longer the source of the upper half.

// File: rtl/insn_seg_pkg.sv
package insn_seg_pkg;

    localparam logic [3:0] TAIL_W0  = 4'hB;
    localparam logic [3:0] TAIL_W10 = 4'hC;
    localparam logic [3:0] TAIL_W15 = 4'hD;
    localparam logic [3:0] TAIL_W16 = 4'hE;

    typedef struct packed {
        logic       ok;
        logic [4:0] nbits;
    } tail_info_t;

    function automatic tail_info_t tail_decode(input logic [3:0] code);
        tail_info_t t;
        t.ok    = 1'b1;
        t.nbits = 5'd0;
        case (code)
            TAIL_W0:  t.nbits = 5'd0;
            TAIL_W10: t.nbits = 5'd10;
            TAIL_W15: t.nbits = 5'd15;
            TAIL_W16: t.nbits = 5'd16;
            default:  t.ok    = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/insn_seg_parse.sv
module insn_seg_parse
    import insn_seg_pkg::*;
#(
    parameter int         WIN_W    = 32,
    parameter int         IDX_MAX  = 9,
    parameter int         SEG_W    = 16,
    parameter int         LEN_W    = 6,
    parameter logic [3:0] CLASS_ID = 4'h6
) (
    input  logic [WIN_W-1:0]   window,
    input  logic [3:0]         idx_len,
    input  logic [3:0]         tail_code,
    output logic               fields_ok,
    output logic               sel,
    output logic [IDX_MAX-1:0] idx,
    output logic [SEG_W-1:0]   tail_val,
    output logic [LEN_W-1:0]   used_len
);
    localparam int HDR_W = 5;

    tail_info_t         ti;
    logic               cls_ok;
    logic               len_ok;
    logic [LEN_W-1:0]   idx_n;
    logic [LEN_W-1:0]   tail_n;
    logic [WIN_W-1:0]   after_hdr;
    logic [WIN_W-1:0]   after_idx;
    logic [IDX_MAX-1:0] idx_raw;
    logic [SEG_W-1:0]   tail_raw;

    always_comb begin
        ti        = tail_decode(tail_code);
        cls_ok    = (window[WIN_W-1 -: 4] == CLASS_ID);
        len_ok    = (int'(idx_len) >= 2) && (int'(idx_len) <= IDX_MAX);
        sel       = window[WIN_W-5];
        idx_n     = len_ok ? LEN_W'(idx_len) : '0;
        tail_n    = LEN_W'(ti.nbits);
        after_hdr = window << HDR_W;
        after_idx = after_hdr << idx_n;
        idx_raw   = after_hdr[WIN_W-1 -: IDX_MAX];
        tail_raw  = after_idx[WIN_W-1 -: SEG_W];
        idx       = len_ok ? (idx_raw >> (LEN_W'(IDX_MAX) - idx_n)) : '0;
        tail_val  = (tail_n == '0) ? '0 : (tail_raw >> (LEN_W'(SEG_W) - tail_n));
        used_len  = LEN_W'(HDR_W) + idx_n + tail_n;
        fields_ok = cls_ok && len_ok && ti.ok;
    end

endmodule

// File: rtl/insn_seg_vocab_port.sv
module insn_seg_vocab_port #(
    parameter int IDX_MAX = 9,
    parameter int VOC_AW  = 9
) (
    input  logic               fire,
    input  logic               picked,
    input  logic [VOC_AW-1:0]  base,
    input  logic [IDX_MAX-1:0] idx,
    output logic               rd_en,
    output logic [VOC_AW-1:0]  rd_addr
);
    always_comb begin
        rd_en   = fire && picked;
        rd_addr = base + VOC_AW'(idx);
    end
endmodule

// File: rtl/insn_seg_expander.sv
module insn_seg_expander
    import insn_seg_pkg::*;
#(
    parameter int         WIN_W    = 32,
    parameter int         IDX_MAX  = 9,
    parameter int         VOC_AW   = 9,
    parameter int         SEG_W    = 16,
    parameter int         LEN_W    = $clog2(WIN_W + 1),
    parameter logic [3:0] CLASS_ID = 4'h6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WIN_W-1:0]     in_window,
    input  logic [3:0]           cfg_idx_len,
    input  logic [3:0]           cfg_tail_code,
    input  logic [VOC_AW-1:0]    cfg_base_a,
    input  logic [VOC_AW-1:0]    cfg_base_b,
    output logic                 voc_a_en,
    output logic [VOC_AW-1:0]    voc_a_addr,
    input  logic [SEG_W-1:0]     voc_a_data,
    output logic                 voc_b_en,
    output logic [VOC_AW-1:0]    voc_b_addr,
    input  logic [SEG_W-1:0]     voc_b_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2*SEG_W-1:0]   out_instr,
    output logic [LEN_W-1:0]     out_len,
    output logic                 out_err
);
    localparam int NRAM = 2;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic             fresh;
        logic             sel;
        logic [SEG_W-1:0] left;
        logic [SEG_W-1:0] right;
        logic [LEN_W-1:0] len;
    } st_t;

    st_t st_d, st_q;

    logic               fields_ok;
    logic               sel;
    logic [IDX_MAX-1:0] idx;
    logic [SEG_W-1:0]   tail_val;
    logic [LEN_W-1:0]   used_len;
    logic               accept;
    logic               fire;
    logic [SEG_W-1:0]   ram_word;

    logic [VOC_AW-1:0]  base_arr [NRAM];
    logic               en_arr   [NRAM];
    logic [VOC_AW-1:0]  addr_arr [NRAM];

    insn_seg_parse #(
        .WIN_W(WIN_W), .IDX_MAX(IDX_MAX), .SEG_W(SEG_W),
        .LEN_W(LEN_W), .CLASS_ID(CLASS_ID)
    ) parse_i (
        .window   (in_window),
        .idx_len  (cfg_idx_len),
        .tail_code(cfg_tail_code),
        .fields_ok(fields_ok),
        .sel      (sel),
        .idx      (idx),
        .tail_val (tail_val),
        .used_len (used_len)
    );

    assign base_arr[0] = cfg_base_a;
    assign base_arr[1] = cfg_base_b;

    for (genvar g = 0; g < NRAM; g++) begin : g_port
        insn_seg_vocab_port #(.IDX_MAX(IDX_MAX), .VOC_AW(VOC_AW)) port_i (
            .fire   (fire),
            .picked (sel == g[0]),
            .base   (base_arr[g]),
            .idx    (idx),
            .rd_en  (en_arr[g]),
            .rd_addr(addr_arr[g])
        );
    end

    assign voc_a_en   = en_arr[0];
    assign voc_a_addr = addr_arr[0];
    assign voc_b_en   = en_arr[1];
    assign voc_b_addr = addr_arr[1];

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;
    assign fire     = accept && fields_ok;
    assign ram_word = st_q.sel ? voc_b_data : voc_a_data;

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.fresh = 1'b0;
        if (st_q.fresh) begin
            st_d.left = ram_word;
        end
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (accept) begin
            if (!fields_ok) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld   = 1'b1;
                st_d.fresh = 1'b1;
                st_d.sel   = sel;
                st_d.right = tail_val;
                st_d.len   = used_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_err   = st_q.err;
    assign out_len   = st_q.len;
    assign out_instr = {(st_q.fresh ? ram_word : st_q.left), st_q.right};

endmodule

// File: rtl/insn_seg_expander_chk.sv
module insn_seg_expander_chk #(
    parameter int SEG_W = 16,
    parameter int LEN_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               voc_a_en,
    input logic               voc_b_en,
    input logic               out_valid,
    input logic               out_ready,
    input logic [2*SEG_W-1:0] out_instr,
    input logic [LEN_W-1:0]   out_len,
    input logic               out_err
);
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_instr) && $stable(out_len));

    a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r5_one_ram: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({voc_a_en, voc_b_en}));

    a_r5_read_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (voc_a_en || voc_b_en) |-> in_valid && in_ready);

    a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (voc_a_en || voc_b_en) |=> out_valid);

    a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !out_valid);

    a_r7_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len >= LEN_W'(7));
endmodule

bind insn_seg_expander insn_seg_expander_chk #(.SEG_W(SEG_W), .LEN_W(LEN_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .voc_a_en (voc_a_en),
    .voc_b_en (voc_b_en),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_instr(out_instr),
    .out_len  (out_len),
    .out_err  (out_err)
);

// File: tb/insn_seg_expander_tb_top.sv
`timescale 1ns/1ps
module insn_seg_expander_tb_top;
    localparam logic [3:0] CLS = 4'h6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_window = '0;
    logic [3:0]  cfg_idx_len = 4'd2;
    logic [3:0]  cfg_tail_code = 4'hB;
    logic [8:0]  cfg_base_a = 9'h1F0;
    logic [8:0]  cfg_base_b = 9'h023;
    logic        voc_a_en, voc_b_en;
    logic [8:0]  voc_a_addr, voc_b_addr;
    logic [15:0] voc_a_data = '0;
    logic [15:0] voc_b_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_instr;
    logic [5:0]  out_len;
    logic        out_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    insn_seg_expander dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_window(in_window), .cfg_idx_len(cfg_idx_len), .cfg_tail_code(cfg_tail_code),
        .cfg_base_a(cfg_base_a), .cfg_base_b(cfg_base_b),
        .voc_a_en(voc_a_en), .voc_a_addr(voc_a_addr), .voc_a_data(voc_a_data),
        .voc_b_en(voc_b_en), .voc_b_addr(voc_b_addr), .voc_b_data(voc_b_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .out_len(out_len), .out_err(out_err)
    );

    function automatic logic [15:0] voc_word(input bit ram_b, input int a);
        return 16'((a * 613) ^ (ram_b ? 16'hA5F0 : 16'h0F0F));
    endfunction

    always @(posedge clk) begin
        if (voc_a_en) voc_a_data <= voc_word(1'b0, int'(voc_a_addr));
        if (voc_b_en) voc_b_data <= voc_word(1'b1, int'(voc_b_addr));
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int tail_bits(input logic [3:0] code);
        case (code)
            4'hB: return 0;
            4'hC: return 10;
            4'hD: return 15;
            default: return 16;
        endcase
    endfunction

    task automatic run_good(input bit s, input int L, input logic [3:0] code,
                            input int idx_v, input int byp_v, input int hold);
        int B, rem, addr;
        logic [31:0] w, exp_ins;
        B   = tail_bits(code);
        rem = 27 - L - B;
        w   = {CLS, 28'h0};
        w   = w | (32'(s) << 27);
        w   = w | (32'(idx_v) << (27 - L));
        w   = w | (32'(byp_v) << rem);
        w   = w | (32'h5555_5555 & ((32'h1 << rem) - 32'h1));
        addr = ((s ? int'(cfg_base_b) : int'(cfg_base_a)) + idx_v) % 512;
        exp_ins = {voc_word(s, addr), 16'(byp_v)};
        @(negedge clk);
        in_window = w; cfg_idx_len = 4'(L); cfg_tail_code = code;
        in_valid = 1'b1; out_ready = (hold == 0);
        #1;
        chk("R5 enables", {30'h0, voc_b_en, voc_a_en}, {30'h0, s, !s});
        chk("R5 address", 32'(s ? voc_b_addr : voc_a_addr), 32'(addr));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 valid", 32'(out_valid), 32'h1);
        chk("R1 R6 R8 instr", out_instr, exp_ins);
        chk("R7 length", 32'(out_len), 32'(5 + L + B));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9 held instr", out_instr, exp_ins);
            chk("R9 in_ready low", 32'(in_ready), 32'h0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", 32'(out_valid), 32'h0);
    endtask

    task automatic run_bad(input logic [3:0] cls, input int L, input logic [3:0] code, input string req);
        @(negedge clk);
        in_window = {cls, 28'hABCDEF1}; cfg_idx_len = 4'(L); cfg_tail_code = code;
        in_valid = 1'b1;
        #1;
        chk({req, " no read"}, {30'h0, voc_b_en, voc_a_en}, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R10 err"}, {30'h0, out_err, out_valid}, 32'h2);
        @(negedge clk);
        chk({req, " R10 pulse ends"}, 32'(out_err), 32'h0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] codes [4];
        int ipat [3];
        int bpat [3];
        codes = '{4'hB, 4'hC, 4'hD, 4'hE};
        ipat  = '{32'h1FF, 0, 32'h155};
        bpat  = '{32'hFFFF, 0, 32'hA5C3};
        repeat (3) @(negedge clk);
        chk("R11 reset state", {29'h0, out_valid, out_err, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after release", {29'h0, out_valid, out_err, in_ready}, 32'h1);
        for (int s = 0; s < 2; s++)
            for (int L = 2; L <= 9; L++)
                for (int c = 0; c < 4; c++)
                    for (int p = 0; p < 3; p++) begin
                        int B;
                        B = tail_bits(codes[c]);
                        run_good(s[0], L, codes[c], ipat[p] & ((1 << L) - 1),
                                 (B == 0) ? 0 : (bpat[p] & ((1 << B) - 1)),
                                 (p == 1) ? 3 : 0);
                    end
        for (int c = 0; c < 16; c++)
            if (c < 11 || c > 14) run_bad(CLS, 4, 4'(c), "R4 bad code");
        for (int L = 0; L < 16; L++)
            if (L < 2 || L > 9) run_bad(CLS, L, 4'hE, "R3 bad length");
        run_bad(CLS ^ 4'h1, 5, 4'hC, "R2 bad class");
        run_bad(4'h0, 5, 4'hC, "R2 bad class");
        run_good(1'b0, 9, 4'hE, 32'h1FF, 32'h8001, 0);
        finish_run();
    end
endmodule